// File: doc/BRIEF.md
# PCM Bit-Clock, Frame-Sync and Sample Serializer

This block is the master side of a short-frame DSP-style audio serial link. It divides a selectable source tick into a serial bit clock, and divides that clock into frames marked by a one-slot sync pulse. Each frame carries one 16-bit word out on the serial data line and captures one 16-bit word from the serial data input, both MSB first.

The bit clock is inverted. Transmit data and sync change on the rising edge of the serial clock, and receive data is sampled on the falling edge. Each direction has its own alignment flag: the MSB either shares the sync slot or follows it by one slot. Transmit words come in on a valid/ready stream and received words leave on another valid/ready stream. Everything runs in the `clk` domain. The two source clocks arrive as single-cycle tick enables.

Top module: `pcm_link_master`

## Requirements
- R1: The serial clock toggles once every D+1 ticks of the selected source, where D is `sclk_div`, so one period takes 2*(D+1) ticks. `src_sel_periph`=1 selects `tick_periph` and 0 selects `tick_audio`. After an idle period the first edge is a rising edge.
- R2: When `sclk_out_en`=0, `sclk_o` is held low while the internal clock and framing keep running. When it is 1, `sclk_o` shows the internal clock.
- R3: The clock runs while `tx_en`, `rx_en` or `clk_continuous` is 1. Otherwise the clock, sync and data outputs are held low and framing restarts, so the next rising edge opens slot 0.
- R4: A frame has F+1 bit-clock slots, where F is `frame_div` and F is at least 16. `fsync_o` is high for exactly slot 0 and changes on rising edges.
- R5: `sdo` sends the frame's word MSB first and changes on rising edges. With `tx_late`=0 the MSB is in slot 0. With `tx_late`=1 it is in slot 1. All other slots send 0.
- R6: `tx_ready` pulses for one cycle, with `tx_en`=1, on the cycle whose rising edge opens slot 0. The word is taken if `tx_valid` is high in that cycle. Without a word, or with `tx_en`=0, the frame sends all zeros.
- R7: `sdi` is sampled on falling edges, MSB first. With `rx_late`=0 slots 0..15 are sampled; with `rx_late`=1 slots 1..16. Nothing is captured while `rx_en`=0.
- R8: A completed word raises `rx_valid`. `rx_valid` and `rx_data` hold until a cycle with `rx_ready`=1. A word that completes while an earlier word is still held and not accepted in that cycle is dropped.
- R9: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_audio | input | 1 | Tick enable of the audio source clock |
| tick_periph | input | 1 | Tick enable of the peripheral source clock |
| src_sel_periph | input | 1 | 1 selects the peripheral tick, 0 the audio tick |
| sclk_div | input | 9 | Half-period of the bit clock minus one, in source ticks |
| frame_div | input | 9 | Frame length minus one, in bit-clock slots |
| sclk_out_en | input | 1 | Drives the bit clock onto `sclk_o` |
| clk_continuous | input | 1 | Keeps the bit clock running while both directions are idle |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_late | input | 1 | Transmit MSB one slot after sync |
| rx_late | input | 1 | Receive MSB one slot after sync |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle |
| tx_data | input | 16 | Transmit word |
| sdi | input | 1 | Serial data in |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word |
| sclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame sync, high during slot 0 |
| sdo | output | 1 | Serial data out |

## Verification
A wrong divider count moves the next `sclk_o` edge within one bit-clock half-period. A wrong slot counter moves `fsync_o` and the `sdo` pattern within one frame. A misaligned transmit or receive shifter shows up as a shifted bit on `sdo` within the same frame, or as a wrong `rx_data` word at the end of that frame. Back-pressure faults show up on the first word that completes while `rx_ready` is low. A reference model compares every output on every cycle, so each of these faults is caught at its first visible cycle.

// File: rtl/pcm_link_pkg.sv
package pcm_link_pkg;
  localparam int DIV_W = 9;   // divider field width
  localparam int SMP_W = 16;  // sample width
endpackage

// File: rtl/pcm_bitclk_gen.sv
module pcm_bitclk_gen #(
  parameter int DW = pcm_link_pkg::DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] div,
  output logic          sclk,
  output logic          rise_ev,
  output logic          fall_ev
);
  logic [DW-1:0] cnt;
  logic          wrap;

  assign wrap    = run & tick & (cnt >= div);
  assign rise_ev = wrap & ~sclk;
  assign fall_ev = wrap & sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      if (cnt >= div) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: without a selected tick the clock holds its level
  p_no_tick_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sclk));
endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int DW = pcm_link_pkg::DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rise_ev,
  input  logic [DW-1:0] fdiv,
  output logic [DW-1:0] slot,
  output logic          frame_start,
  output logic          fsync
);
  logic [DW-1:0] slot_n;

  // an idle slot value of all ones wraps to slot 0 on the first rise
  assign slot_n      = (slot >= fdiv) ? '0 : slot + 1'b1;
  assign frame_start = rise_ev & (slot_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '1;
      fsync <= 1'b0;
    end else if (!run) begin
      slot  <= '1;
      fsync <= 1'b0;
    end else if (rise_ev) begin
      slot  <= slot_n;
      fsync <= frame_start;
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int SW = pcm_link_pkg::SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rise_ev,
  input  logic          frame_start,
  input  logic          tx_en,
  input  logic          late,
  input  logic          tx_valid,
  input  logic [SW-1:0] tx_data,
  output logic          tx_ready,
  output logic          sd
);
  logic [SW-1:0] sh;
  logic [SW-1:0] load;

  assign tx_ready = frame_start & tx_en;
  assign load     = (tx_ready & tx_valid) ? tx_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      sd <= 1'b0;
    end else if (!run) begin
      sh <= '0;
      sd <= 1'b0;
    end else if (rise_ev) begin
      if (frame_start) begin
        if (late) begin
          sd <= 1'b0;
          sh <= load;
        end else begin
          sd <= load[SW-1];
          sh <= load << 1;
        end
      end else begin
        sd <= sh[SW-1];
        sh <= sh << 1;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int SW = pcm_link_pkg::SMP_W,
  parameter int DW = pcm_link_pkg::DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fall_ev,
  input  logic [DW-1:0] slot,
  input  logic          late,
  input  logic          rx_en,
  input  logic          sdi,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [SW-1:0] rx_data
);
  localparam logic [DW-1:0] SPAN = DW'(SW - 1);

  logic [SW-1:0] sh;
  logic [DW-1:0] first_slot, last_slot;
  logic          take, done;

  assign first_slot = {{(DW-1){1'b0}}, late};
  assign last_slot  = first_slot + SPAN;
  assign take = fall_ev & rx_en & (slot >= first_slot) & (slot <= last_slot);
  assign done = take & (slot == last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (!run)   sh <= '0;
    else if (take)   sh <= {sh[SW-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (done && (!rx_valid || rx_ready)) begin
        rx_valid <= 1'b1;
        rx_data  <= {sh[SW-2:0], sdi};
      end
    end
  end

  // R8: a held word is not lost or altered while the consumer stalls
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: rtl/pcm_link_master.sv
module pcm_link_master #(
  parameter int DW = pcm_link_pkg::DIV_W,
  parameter int SW = pcm_link_pkg::SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_audio,
  input  logic          tick_periph,
  input  logic          src_sel_periph,
  input  logic [DW-1:0] sclk_div,
  input  logic [DW-1:0] frame_div,
  input  logic          sclk_out_en,
  input  logic          clk_continuous,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          tx_late,
  input  logic          rx_late,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [SW-1:0] tx_data,
  input  logic          sdi,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [SW-1:0] rx_data,
  output logic          sclk_o,
  output logic          fsync_o,
  output logic          sdo
);
  logic          run, tick, sclk_int, rise_ev, fall_ev, frame_start;
  logic [DW-1:0] slot;

  assign run    = tx_en | rx_en | clk_continuous;
  assign tick   = src_sel_periph ? tick_periph : tick_audio;
  assign sclk_o = sclk_int & sclk_out_en;

  pcm_bitclk_gen #(.DW(DW)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .div(sclk_div),
    .sclk(sclk_int), .rise_ev(rise_ev), .fall_ev(fall_ev));

  pcm_frame_ctr #(.DW(DW)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(run), .rise_ev(rise_ev), .fdiv(frame_div),
    .slot(slot), .frame_start(frame_start), .fsync(fsync_o));

  pcm_tx_shift #(.SW(SW)) u_tx (
    .clk(clk), .rst_n(rst_n), .run(run), .rise_ev(rise_ev),
    .frame_start(frame_start), .tx_en(tx_en), .late(tx_late),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .sd(sdo));

  pcm_rx_shift #(.SW(SW), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .run(run), .fall_ev(fall_ev), .slot(slot),
    .late(rx_late), .rx_en(rx_en), .sdi(sdi), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data));

  // R4: sync only starts together with a rising bit-clock edge
  p_sync_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_o) |-> sclk_int);

  // R5: serial data moves only on rising edges while the link runs
  p_sdo_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(sdo)) |-> $past(rise_ev));

  // R6: no transmit handshake while the direction is disabled
  p_ready_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_en && $rose(sclk_int) == 1'b0));
endmodule

// File: tb/sim_pcm_link_master.sv
module sim_pcm_link_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_audio = 0, tick_periph = 0, src_sel_periph = 0;
  logic [8:0] sclk_div = 0, frame_div = 16;
  logic sclk_out_en = 1, clk_continuous = 0, tx_en = 0, rx_en = 0;
  logic tx_late = 0, rx_late = 0, tx_valid = 0, sdi = 0, rx_ready = 1;
  logic [15:0] tx_data = 0;
  logic tx_ready, rx_valid, sclk_o, fsync_o, sdo;
  logic [15:0] rx_data;

  int checks = 0, errors = 0;
  int lfsr = 32'h1ace;
  bit feed = 1, tick_always = 1, rdy_rand = 0, rdy_low = 0;
  logic [15:0] txq[$];
  bit pop;

  // reference state
  int m_div, m_slot = -1, idx;
  bit m_sclk, m_fs, m_sd, m_rv;
  logic [15:0] m_word, m_acc, m_rd;

  always #4 clk = ~clk;

  pcm_link_master u0 (.*);

  function automatic bit runv();
    return tx_en | rx_en | clk_continuous;
  endfunction
  function automatic bit tickv();
    return src_sel_periph ? tick_periph : tick_audio;
  endfunction

  task automatic chk(input string tag, input string nm, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // reference model, one step per clock
  always @(posedge clk) begin
    bit done, acc, oldv;
    done = 0;
    pop = tx_valid && tx_ready;
    if (!rst_n) begin
      m_div = 0; m_sclk = 0; m_slot = -1; m_fs = 0; m_sd = 0;
      m_word = 0; m_acc = 0; m_rv = 0; m_rd = 0;
    end else begin
      if (!runv()) begin
        m_div = 0; m_sclk = 0; m_slot = -1; m_fs = 0; m_sd = 0; m_word = 0; m_acc = 0;
      end else if (tickv()) begin
        if (m_div >= int'(sclk_div)) begin
          m_div = 0;
          if (!m_sclk) begin
            m_slot = (m_slot < 0 || m_slot >= int'(frame_div)) ? 0 : m_slot + 1;
            if (m_slot == 0) m_word = (tx_en && tx_valid) ? tx_data : 16'h0;
            idx = m_slot - int'(tx_late);
            m_sd = (idx >= 0 && idx < 16) ? m_word[15-idx] : 1'b0;
            m_fs = (m_slot == 0);
          end else begin
            idx = m_slot - int'(rx_late);
            if (rx_en && idx >= 0 && idx < 16) begin
              m_acc = {m_acc[14:0], sdi};
              if (idx == 15) done = 1;
            end
          end
          m_sclk = !m_sclk;
        end else m_div++;
      end
      oldv = m_rv;
      acc = m_rv && rx_ready;
      if (acc) m_rv = 0;
      if (done && (!oldv || rx_ready)) begin m_rv = 1; m_rd = m_acc; end
    end
  end

  // compare registered outputs, then drive the streams, then check tx_ready
  always @(negedge clk) begin
    string ts;
    int nxt;
    bit exp_rdy;
    ts = !rst_n ? "R9" : (!sclk_out_en ? "R2" : (!runv() ? "R3" : "R1"));
    chk(ts, "sclk_o", 16'(sclk_o), 16'(m_sclk & sclk_out_en));
    chk(!rst_n ? "R9" : "R4", "fsync_o", 16'(fsync_o), 16'(m_fs));
    chk(!rst_n ? "R9" : ((tx_en && !feed) ? "R6" : "R5"), "sdo", 16'(sdo), 16'(m_sd));
    chk(!rst_n ? "R9" : "R8", "rx_valid", 16'(rx_valid), 16'(m_rv));
    chk(!rst_n ? "R9" : "R7", "rx_data", rx_data, m_rd);
    if (pop && txq.size() > 0) void'(txq.pop_front());
    lfsr = (lfsr << 1) ^ ((lfsr >> 15) & 1 ? 32'h1021 : 0) ^ (lfsr >> 7);
    lfsr = lfsr & 32'hffff;
    if (lfsr == 0) lfsr = 1;
    tick_audio  = tick_always ? 1'b1 : lfsr[2];
    tick_periph = tick_always ? 1'b1 : lfsr[5];
    sdi = lfsr[9];
    rx_ready = rdy_low ? 1'b0 : (rdy_rand ? lfsr[11] : 1'b1);
    tx_valid = feed && txq.size() > 0;
    tx_data  = txq.size() > 0 ? txq[0] : 16'h0;
    #1;
    nxt = (m_slot < 0 || m_slot >= int'(frame_div)) ? 0 : m_slot + 1;
    exp_rdy = rst_n && tx_en && tickv() && m_div >= int'(sclk_div) && !m_sclk && nxt == 0;
    chk(!rst_n ? "R9" : "R6", "tx_ready", 16'(tx_ready), 16'(exp_rdy));
  end

  task automatic cfg_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fill(input int n, input logic [15:0] seed);
    for (int i = 0; i < n; i++) txq.push_back(seed ^ 16'(i * 16'h3b5d));
  endtask

  initial begin
    cfg_wait(5);
    rst_n = 1;
    // R1 R4 R5 R7: audio source, fastest clock, MSB with sync
    fill(30, 16'h8001);
    tx_en = 1; rx_en = 1;
    cfg_wait(700);
    // R3: gated idle
    tx_en = 0; rx_en = 0;
    cfg_wait(30);
    // R1 R5 R7 R8: peripheral source, slower clock, late MSB, stalling consumer
    src_sel_periph = 1; sclk_div = 2; frame_div = 20; tx_late = 1; rx_late = 1;
    tick_always = 0; rdy_rand = 1; fill(40, 16'hc3a5);
    tx_en = 1; rx_en = 1;
    cfg_wait(3000);
    tx_en = 0; rx_en = 0;
    cfg_wait(20);
    // R6: transmit with no words offered sends zeros
    feed = 0; tx_late = 0; src_sel_periph = 0; sclk_div = 1;
    tx_en = 1;
    cfg_wait(1200);
    tx_en = 0; feed = 1;
    cfg_wait(20);
    // R3 R2: continuous clock while idle, then output gated off
    clk_continuous = 1; frame_div = 17;
    cfg_wait(800);
    sclk_out_en = 0;
    cfg_wait(300);
    sclk_out_en = 1; clk_continuous = 0;
    cfg_wait(20);
    // R7 R8: receive only, late MSB, long stall drops words
    rx_late = 1; tx_late = 0; frame_div = 31; sclk_div = 0; rdy_rand = 0; rdy_low = 1;
    rx_en = 1;
    cfg_wait(1500);
    rdy_low = 0;
    cfg_wait(1000);
    rx_en = 0;
    cfg_wait(20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule